// File: doc/BRIEF.md
# Periodic Sensing Window Controller

This block paces the spectrum-sensing slots of a half-duplex radio node. A free-running period counter reaches its terminal count at a fixed rate. The default rate is ten times per second at an 80 MHz sample clock. At each terminal count the block asks for a short capture window. While the window is open, the transmitter is held off and received samples are passed to the sensing buffer. Only one sample in every `DECIM` is kept, which matches the slower rate of the sensing path. Each kept sample carries a type tag that tells the downstream processor it is sensing data.

A packet that is being transmitted when the period expires is not cut off. The window waits for the packet boundary, which is the first cycle in which `tx_busy` is low. A watchdog forces the window open after at most `MAX_DEFER` cycles of waiting. The period counter keeps running while the window is delayed, so the long-term window rate does not drift. When the window closes, a one-cycle done pulse follows and the transmitter is enabled again.

The default parameters place the end of the whole cycle within 1 ms of the terminal count: a 320-cycle window, a 64 000-cycle watchdog and the closing cycle, which is 64 321 cycles at most. A terminal count that arrives while a window is still pending or running is dropped. Parameters that keep `PERIOD_CYC` above that worst case never reach this case.

Top module: `sense_window_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `tx_en` is 1 and `cap_valid`, `cap_stb`, `sense_done`, `tag` and `cap_data` are all 0. The period counter starts at zero, so the first terminal count occurs at the `PERIOD_CYC`-th rising edge after reset is released.
- R2: Terminal counts occur every `PERIOD_CYC` clock edges without pause, whether or not a window was delayed.
- R3: If `tx_busy` is low at the edge after a terminal count, `cap_valid` goes high from that edge on.
- R4: While `tx_busy` stays high after a terminal count, the window is deferred. It opens at the first edge that sees `tx_busy` low.
- R5: If `tx_busy` stays high, the window is forced open at the (`MAX_DEFER`+1)-th edge after the terminal-count edge.
- R6: `cap_valid` stays high for exactly `WIN_CYC` consecutive cycles, and `tx_en` is 0 in every one of those cycles.
- R7: In the cycle right after `cap_valid` falls, `tx_en` is still 0. In the cycle after that, `tx_en` is 1.
- R8: `sense_done` is high for exactly one cycle, the first cycle after `cap_valid` falls, and is 0 at all other times.
- R9: `cap_stb` is high in window cycles 0, `DECIM`, 2·`DECIM` and so on, counted from the first cycle of the window. In those cycles `cap_data` equals `rx_sample`; at all other times `cap_data` is 0. A window therefore holds `WIN_CYC`/`DECIM` strobes.
- R10: `tag` is `SENSE_TAG` (default 3) while `cap_valid` is high, and 0 otherwise.
- R11: `sense_done` arrives no more than `MAX_DEFER`+`WIN_CYC`+1 edges after the terminal-count edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_busy | input | 1 | High while a transmit packet is in progress |
| rx_sample | input | DW | Received sample, one per clock |
| tx_en | output | 1 | Transmit path enable |
| cap_valid | output | 1 | High for the duration of the capture window |
| cap_stb | output | 1 | Marks a kept (decimated) sample |
| cap_data | output | DW | Kept sample, 0 when `cap_stb` is low |
| sense_done | output | 1 | One-cycle pulse after the window closes |
| tag | output | TAG_W | Data-type tag, `SENSE_TAG` during the window |

## Verification
The bench builds the block with `PERIOD_CYC`=400, `WIN_CYC`=40, `DECIM`=8 and `MAX_DEFER`=30. These values make several full periods fit in a few thousand cycles. With them the bench can hit a window that opens on time, one deferred by a packet that ends before the watchdog, one forced open by the watchdog, and one inside irregular busy bursts. A reset in the middle of the run shows the period restarting from zero. A behavioural model, tracked as edge numbers, predicts every output on every cycle.

// File: rtl/sense_window_ctrl.sv
module sense_window_ctrl #(
  parameter int unsigned PERIOD_CYC = 8_000_000,
  parameter int unsigned WIN_CYC    = 320,
  parameter int unsigned DECIM      = 16,
  parameter int unsigned MAX_DEFER  = 64_000,
  parameter int unsigned DW         = 16,
  parameter int unsigned TAG_W      = 2,
  parameter int unsigned SENSE_TAG  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_busy,
  input  logic [DW-1:0]    rx_sample,
  output logic             tx_en,
  output logic             cap_valid,
  output logic             cap_stb,
  output logic [DW-1:0]    cap_data,
  output logic             sense_done,
  output logic [TAG_W-1:0] tag
);
  localparam int unsigned PW  = $clog2(PERIOD_CYC);
  localparam int unsigned WW  = $clog2(WIN_CYC);
  localparam int unsigned FW  = $clog2(MAX_DEFER + 1);
  localparam int unsigned DCW = (DECIM > 1) ? $clog2(DECIM) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CAP, S_TAIL} st_t;

  st_t            st;
  logic [PW-1:0]  pcnt;
  logic [FW-1:0]  fcnt;
  logic [WW-1:0]  wcnt;
  logic [DCW-1:0] ph;
  logic           period_tick;
  logic           open_now;
  logic           win_last;

  assign period_tick = (pcnt == PW'(PERIOD_CYC - 1));
  assign open_now    = !tx_busy || (fcnt == FW'(MAX_DEFER));
  assign win_last    = (wcnt == WW'(WIN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= period_tick ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      fcnt <= '0;
      wcnt <= '0;
      ph   <= '0;
    end else begin
      case (st)
        S_IDLE: if (period_tick) begin
          st   <= S_WAIT;
          fcnt <= '0;
        end
        S_WAIT: if (open_now) begin
          st   <= S_CAP;
          wcnt <= '0;
          ph   <= '0;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
        S_CAP: begin
          if (win_last) st <= S_TAIL;
          wcnt <= wcnt + 1'b1;
          ph   <= (ph == DCW'(DECIM - 1)) ? '0 : ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cap_valid  = (st == S_CAP);
  assign sense_done = (st == S_TAIL);
  assign tx_en      = !(cap_valid || sense_done);
  assign cap_stb    = cap_valid && (ph == '0);
  assign cap_data   = cap_stb ? rx_sample : '0;
  assign tag        = cap_valid ? TAG_W'(SENSE_TAG) : '0;
endmodule

// File: rtl/sense_window_chk.sv
module sense_window_chk #(
  parameter int unsigned WIN_CYC   = 320,
  parameter int unsigned MAX_DEFER = 64_000,
  parameter int unsigned TAG_W     = 2,
  parameter int unsigned SENSE_TAG = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             cap_valid,
  input logic             cap_stb,
  input logic             sense_done,
  input logic [TAG_W-1:0] tag,
  input logic             period_tick
);
  int unsigned run;
  int unsigned since;
  logic        armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else        run <= cap_valid ? run + 1 : 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      since <= 0;
    end else if (sense_done) begin
      armed <= 1'b0;
    end else if (period_tick && !armed) begin
      armed <= 1'b1;
      since <= 0;
    end else if (armed) begin
      since <= since + 1;
    end
  end

  a_r6_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> !tx_en);
  a_r6_win_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_valid) |-> run == WIN_CYC);
  a_r6_win_max: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> run < WIN_CYC);
  a_r7_tx_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_valid) |=> tx_en);
  a_r8_done_after_win: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_valid) |-> sense_done && !tx_en);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sense_done |=> !sense_done);
  a_r9_stb_in_win: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> cap_valid);
  a_r10_tag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> tag == TAG_W'(SENSE_TAG));
  a_r11_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> since <= MAX_DEFER + WIN_CYC + 1);
endmodule

bind sense_window_ctrl sense_window_chk #(
  .WIN_CYC(WIN_CYC), .MAX_DEFER(MAX_DEFER), .TAG_W(TAG_W), .SENSE_TAG(SENSE_TAG)
) i_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cap_valid(cap_valid),
  .cap_stb(cap_stb), .sense_done(sense_done), .tag(tag),
  .period_tick(period_tick)
);

// File: tb/test_sense_window_ctrl.sv
`timescale 1ns/1ps
module test_sense_window_ctrl;
  localparam int PERIOD = 400;
  localparam int WIN    = 40;
  localparam int DEC    = 8;
  localparam int MAXD   = 30;
  localparam int DW     = 16;
  localparam int NCYC   = 3000;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          tx_busy = 0;
  logic [DW-1:0] rx_sample = '0;
  logic          tx_en, cap_valid, cap_stb, sense_done;
  logic [DW-1:0] cap_data;
  logic [1:0]    tag;

  sense_window_ctrl #(.PERIOD_CYC(PERIOD), .WIN_CYC(WIN), .DECIM(DEC),
    .MAX_DEFER(MAXD), .DW(DW), .TAG_W(2), .SENSE_TAG(3)) i_sense_window_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .rx_sample(rx_sample),
    .tx_en(tx_en), .cap_valid(cap_valid), .cap_stb(cap_stb),
    .cap_data(cap_data), .sense_done(sense_done), .tag(tag));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural model in edge numbers
  int e = 0, open_e = -1, wait_from = -1, done_cnt = 0;

  function automatic bit m_cv();
    return open_e >= 0 && e >= open_e && e < open_e + WIN;
  endfunction
  function automatic bit m_sd();
    return open_e >= 0 && e == open_e + WIN;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e = 0; open_e = -1; wait_from = -1;
    end else begin
      bit busy_prev;
      e = e + 1;
      busy_prev = open_e >= 0 && (e - 1) >= open_e && (e - 1) <= open_e + WIN;
      if (wait_from >= 0) begin
        if (!tx_busy || (e - wait_from - 1) == MAXD) begin
          open_e = e; wait_from = -1;
        end
      end else if (e % PERIOD == 0 && !busy_prev) begin
        wait_from = e;
      end
      if (m_sd()) done_cnt++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic bit busy_at(int c);
    return (c >= 395 && c < 415) || (c >= 790 && c < 880) ||
           (c >= 1500 && c < 1700 && (c % 7) < 3) || (c >= 2390 && c < 2415);
  endfunction

  int stb_seen = 0, rtl_done = 0;

  initial begin
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      if (c == 3 || c == 1955) rst_n = 1;
      if (c == 1950) rst_n = 0;
      if (!rst_n) begin
        chk(tx_en == 1'b1, "R1 tx_en in reset", tx_en, 1);
        chk(cap_valid == 1'b0 && sense_done == 1'b0 && cap_stb == 1'b0,
            "R1 flags in reset", {cap_valid, sense_done, cap_stb}, 0);
        chk(tag == 2'd0 && cap_data == '0, "R1 tag/data in reset", tag, 0);
      end else begin
        bit cv, sd, stb;
        cv  = m_cv();
        sd  = m_sd();
        stb = cv && ((e - open_e) % DEC == 0);
        chk(cap_valid == cv, "R2 R3 R4 R5 R6 cap_valid", cap_valid, cv);
        chk(tx_en == !(cv || sd), "R6 R7 tx_en", tx_en, !(cv || sd));
        chk(sense_done == sd, "R8 R11 sense_done", sense_done, sd);
        chk(cap_stb == stb, "R9 cap_stb", cap_stb, stb);
        chk(cap_data == (stb ? rx_sample : '0), "R9 cap_data", cap_data,
            stb ? rx_sample : 0);
        chk(tag == (cv ? 2'd3 : 2'd0), "R10 tag", tag, cv ? 3 : 0);
        if (cap_stb) stb_seen++;
        if (sense_done) begin
          rtl_done++;
          chk(stb_seen == WIN / DEC, "R9 strobes per window", stb_seen, WIN / DEC);
          stb_seen = 0;
        end
      end
      tx_busy   = busy_at(c);
      rx_sample = DW'(c * 37 + 5);
    end
    chk(rtl_done == done_cnt && rtl_done >= 5, "R2 window count", rtl_done, done_cnt);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #((NCYC + 500) * 10);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule